// File: doc/BRIEF.md
# Sequential Page Read Latency Tracker

This block sits beside the command decoder of a NOR-style flash read port and labels every read access as either a slow first access or a fast access within a page. A page is eight consecutive words that share their upper address bits. While the decoder holds the page-read mode level high, the tracker follows chip enable, output enable and the word address. It reports, for each access, a fast/slow flag and the number of wait cycles that the read path must insert.

A read access is recognised when output enable goes from high to low while chip enable is low. The fast path needs three things: chip enable has stayed low since the previous access, the upper address bits are unchanged, and the low three bits are one more than last time. The run must start at word 0 and ends after word 7. Anything else falls back to the slow timing. A new run then begins only from a slow access at word 0.

Top module: `spr_latency_tracker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, acc_valid, acc_fast and wait_cycles are all 0.
- R2: A sampled high-to-low change of oe_n with ce_n low at that clock edge raises acc_valid for exactly the one cycle after that edge. No pulse is produced while ce_n is high.
- R3: With seq_mode_en low, every access is slow: acc_fast = 0 and wait_cycles = SLOW_CYC (default 6).
- R4: The first access after ce_n falls is slow.
- R5: An access whose low three address bits equal the previous access's low bits plus one is fast, with acc_fast = 1 and wait_cycles = FAST_CYC (default 2). This needs the same upper bits, ce_n low throughout and an armed run.
- R6: An access whose low bits skip ahead or repeat the previous value is slow.
- R7: An access to a different page (different upper address bits) before the run ends is slow.
- R8: After word 7 of a page is read, the next access is slow even if ce_n stays low.
- R9: If ce_n goes high between two accesses, the second is slow even when its address continues the sequence.
- R10: Only a slow access at low bits 0 arms a run. After a slow access at any other word, the following accesses stay slow until one at word 0.
- R11: wait_cycles and acc_fast hold their values between accesses.
- R12: Dropping seq_mode_en in the middle of a page makes the next access slow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low; falling edge marks an access |
| addr | input | ADDR_W | Word address; low PAGE_W bits select the word in the page |
| seq_mode_en | input | 1 | Page-read mode level from the command decoder |
| acc_valid | output | 1 | One-cycle pulse after each recognised access |
| acc_fast | output | 1 | 1 = fast in-page access, 0 = slow first access |
| wait_cycles | output | CNT_W | Wait-state count for the last access |

## Verification
On every cycle the assertions check three things. An access pulse needs chip enable and output enable low on the previous edge. A fast classification needs the mode level and an unbroken chip enable on the previous edge, and is never given at word 0. The wait count matches the flag and does not move between accesses. Only the directed scenarios can show the sequence rules: skips, repeats, page changes, the end of a page and re-arming from word 0. Those scenarios also show that the exact word which breaks a run falls back to the slow timing.

// File: rtl/spr_pkg.sv
`timescale 1ns/1ps
// Shared types for the sequential page read latency tracker.
// Assumes: nothing beyond the types themselves.
package spr_pkg;
    typedef enum logic {
        ACC_SLOW = 1'b0,
        ACC_FAST = 1'b1
    } acc_kind_e;
endpackage

// File: rtl/spr_access_detect.sv
`timescale 1ns/1ps
// Detects one read access per sampled falling edge of output enable
// while chip enable is low.
// Assumes: ce_n and oe_n are already synchronous to clk.
module spr_access_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n_i,
    input  logic oe_n_i,
    output logic fire_o
);
    logic oe_q;

    // Remember the previous sampled output-enable level.
    always_ff @(posedge clk) begin
        if (!rst_n) oe_q <= 1'b1;
        else        oe_q <= oe_n_i;
    end

    // An access begins where output enable falls under a low chip enable.
    always_comb fire_o = !ce_n_i && !oe_n_i && oe_q;

    // R2
    fire_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> (!ce_n_i && $past(oe_n_i)));
endmodule

// File: rtl/spr_page_tracker.sv
`timescale 1ns/1ps
// Tracks the run of sequential words inside one page and classifies the
// current access as slow or fast.
// Assumes: fire_i is high for exactly one cycle per access. A run is
// armed only by a slow access at word 0 and is dropped by ce_n high
// or mode off.
module spr_page_tracker
    import spr_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int PAGE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n_i,
    input  logic              mode_en_i,
    input  logic              fire_i,
    input  logic [ADDR_W-1:0] addr_i,
    output acc_kind_e         kind_o
);
    localparam int TAG_W = ADDR_W - PAGE_W;
    localparam logic [PAGE_W-1:0] LAST_WORD = '1;

    logic              run_q;
    logic [TAG_W-1:0]  tag_q;
    logic [PAGE_W-1:0] low_q;
    logic [TAG_W-1:0]  cur_tag;
    logic [PAGE_W-1:0] cur_low;
    logic              seq_ok;

    // Split the address into page tag and word index.
    always_comb begin
        cur_tag = addr_i[ADDR_W-1:PAGE_W];
        cur_low = addr_i[PAGE_W-1:0];
    end

    // Decide whether this access continues the armed run.
    always_comb begin
        seq_ok = mode_en_i && run_q && (cur_tag == tag_q)
                 && (low_q != LAST_WORD) && (cur_low == low_q + 1'b1);
        kind_o = seq_ok ? ACC_FAST : ACC_SLOW;
    end

    // Maintain the run state across accesses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            tag_q <= '0;
            low_q <= '0;
        end else if (!mode_en_i || ce_n_i) begin
            run_q <= 1'b0;
        end else if (fire_i) begin
            if (seq_ok) begin
                low_q <= cur_low;
            end else if (cur_low == '0) begin
                run_q <= 1'b1;
                tag_q <= cur_tag;
                low_q <= '0;
            end else begin
                run_q <= 1'b0;
            end
        end
    end

    // R9
    fast_needs_ce_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && kind_o == ACC_FAST) |-> $past(!ce_n_i));
    // R12
    fast_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && kind_o == ACC_FAST) |-> ($past(mode_en_i) && mode_en_i));
    // R10
    no_fast_at_word0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && kind_o == ACC_FAST) |-> (cur_low != '0));
endmodule

// File: rtl/spr_latency_out.sv
`timescale 1ns/1ps
// Registers the classification of each access together with its wait count.
// Assumes: FAST_CYC and SLOW_CYC both fit in CNT_W bits.
module spr_latency_out
    import spr_pkg::*;
#(
    parameter int SLOW_CYC = 6,
    parameter int FAST_CYC = 2,
    parameter int CNT_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire_i,
    input  acc_kind_e        kind_i,
    output logic             valid_o,
    output logic             fast_o,
    output logic [CNT_W-1:0] wait_o
);
    localparam logic [CNT_W-1:0] SLOW_V = CNT_W'(SLOW_CYC);
    localparam logic [CNT_W-1:0] FAST_V = CNT_W'(FAST_CYC);

    // Latch the flag and wait count at each access; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            fast_o  <= 1'b0;
            wait_o  <= '0;
        end else begin
            valid_o <= fire_i;
            if (fire_i) begin
                fast_o <= (kind_i == ACC_FAST);
                wait_o <= (kind_i == ACC_FAST) ? FAST_V : SLOW_V;
            end
        end
    end

    // R11
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_i |=> ($stable(wait_o) && $stable(fast_o)));
endmodule

// File: rtl/spr_latency_tracker.sv
`timescale 1ns/1ps
// Top of the sequential page read latency tracker: access detection,
// page run tracking and registered latency output.
// Assumes: inputs are synchronous to clk; seq_mode_en is a level set and
// cleared by the command decoder.
module spr_latency_tracker
    import spr_pkg::*;
#(
    parameter int ADDR_W   = 22,
    parameter int PAGE_W   = 3,
    parameter int SLOW_CYC = 6,
    parameter int FAST_CYC = 2,
    parameter int CNT_W    = $clog2(SLOW_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              seq_mode_en,
    output logic              acc_valid,
    output logic              acc_fast,
    output logic [CNT_W-1:0]  wait_cycles
);
    logic      fire;
    acc_kind_e kind;

    spr_access_detect u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_n_i (ce_n),
        .oe_n_i (oe_n),
        .fire_o (fire)
    );

    spr_page_tracker #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) u_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n_i    (ce_n),
        .mode_en_i (seq_mode_en),
        .fire_i    (fire),
        .addr_i    (addr),
        .kind_o    (kind)
    );

    spr_latency_out #(
        .SLOW_CYC (SLOW_CYC),
        .FAST_CYC (FAST_CYC),
        .CNT_W    (CNT_W)
    ) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (fire),
        .kind_i  (kind),
        .valid_o (acc_valid),
        .fast_o  (acc_fast),
        .wait_o  (wait_cycles)
    );

    // R2
    pulse_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> $past(!ce_n && !oe_n));
    // R5
    fast_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_fast) |-> (wait_cycles == CNT_W'(FAST_CYC)));
    // R3
    slow_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_fast) |-> (wait_cycles == CNT_W'(SLOW_CYC)));
endmodule

// File: tb/spr_latency_tracker_tb_top.sv
`timescale 1ns/1ps
module spr_latency_tracker_tb_top;
    localparam int ADDR_W = 22;
    localparam int SLOW   = 6;
    localparam int FAST   = 2;
    localparam int CW     = $clog2(SLOW + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ce_n = 1'b1;
    logic              oe_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic              seq_mode_en = 1'b0;
    logic              acc_valid;
    logic              acc_fast;
    logic [CW-1:0]     wait_cycles;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    spr_latency_tracker #(.ADDR_W(ADDR_W), .SLOW_CYC(SLOW), .FAST_CYC(FAST)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .addr(addr),
        .seq_mode_en(seq_mode_en), .acc_valid(acc_valid), .acc_fast(acc_fast),
        .wait_cycles(wait_cycles)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] mk(int page, int word);
        return ADDR_W'((page << 3) | word);
    endfunction

    // One access; checks pulse, flag, wait count and hold on the next cycle.
    task automatic rd(string req, logic [ADDR_W-1:0] a, bit exp_fast);
        @(negedge clk); addr = a; oe_n = 1'b1;
        @(negedge clk); oe_n = 1'b0;
        @(negedge clk);
        chk({req, " valid"}, acc_valid, 1);
        chk({req, " fast"}, acc_fast, exp_fast);
        chk({req, " wait"}, wait_cycles, exp_fast ? FAST : SLOW);
        oe_n = 1'b1;
        @(negedge clk);
        chk("R2 single pulse", acc_valid, 0);
        chk("R11 hold", wait_cycles, exp_fast ? FAST : SLOW);
    endtask

    task automatic ce_low();
        @(negedge clk); ce_n = 1'b0;
    endtask

    task automatic ce_high();
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", acc_valid, 0);
        chk("R1 fast in reset", acc_fast, 0);
        chk("R1 wait in reset", wait_cycles, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", acc_valid, 0);
        chk("R1 wait after reset", wait_cycles, 0);
    endtask

    task automatic t_no_ce();
        seq_mode_en = 1'b1; ce_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); oe_n = 1'b0;
            @(negedge clk); chk("R2 no pulse ce high", acc_valid, 0);
            oe_n = 1'b1;
            @(negedge clk); chk("R2 no pulse ce high", acc_valid, 0);
        end
    endtask

    task automatic t_full_page();
        seq_mode_en = 1'b1; ce_low();
        rd("R4 first access", mk(5, 0), 1'b0);
        for (int w = 1; w < 8; w++) rd("R5 in-page", mk(5, w), 1'b1);
        rd("R8 after word 7", mk(5, 0), 1'b0);
        rd("R10 rearmed from word 0", mk(5, 1), 1'b1);
        ce_high();
    endtask

    task automatic t_skip();
        ce_low();
        rd("R4 first access", mk(9, 0), 1'b0);
        rd("R5 in-page", mk(9, 1), 1'b1);
        rd("R6 skip", mk(9, 3), 1'b0);
        rd("R10 not armed", mk(9, 4), 1'b0);
        rd("R10 rearm word 0", mk(9, 0), 1'b0);
        rd("R5 after rearm", mk(9, 1), 1'b1);
        rd("R6 repeat", mk(9, 1), 1'b0);
        ce_high();
    endtask

    task automatic t_page_change();
        ce_low();
        rd("R4 first access", mk(2, 0), 1'b0);
        rd("R5 in-page", mk(2, 1), 1'b1);
        rd("R7 other page", mk(3, 2), 1'b0);
        ce_high();
    endtask

    task automatic t_ce_break();
        ce_low();
        rd("R4 first access", mk(7, 0), 1'b0);
        rd("R5 in-page", mk(7, 1), 1'b1);
        ce_high();
        ce_low();
        rd("R9 ce break", mk(7, 2), 1'b0);
        ce_high();
    endtask

    task automatic t_mode();
        seq_mode_en = 1'b0; ce_low();
        rd("R3 mode off", mk(4, 0), 1'b0);
        rd("R3 mode off", mk(4, 1), 1'b0);
        rd("R3 mode off", mk(4, 2), 1'b0);
        ce_high();
        seq_mode_en = 1'b1; ce_low();
        rd("R4 first access", mk(4, 0), 1'b0);
        rd("R5 in-page", mk(4, 1), 1'b1);
        @(negedge clk); seq_mode_en = 1'b0;
        @(negedge clk); seq_mode_en = 1'b1;
        rd("R12 mode dropped", mk(4, 2), 1'b0);
        ce_high();
    endtask

    initial begin
        t_reset();
        t_no_ce();
        t_full_page();
        t_skip();
        t_page_change();
        t_ce_break();
        t_mode();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule